// File: doc/BRIEF.md
# Output-Driven Wake Request Generator

This block watches the eight outputs of a small programmable logic fabric and turns a chosen subset of them into one wake-up/interrupt request. A per-output enable mask selects which outputs take part, and the selected outputs are ORed into a raw request.

The raw request then follows one of two paths. In the direct path it is captured on the fabric clock, which gives a clean, glitch-free request. In this path an optional sticky mode holds the request high until software writes a one-cycle clear. In the filtered path the raw request first passes through a two-flop synchronizer. It then goes through a digital glitch filter that samples on filter-clock ticks and only accepts a new level after it has held for 1, 2 or 3 ticks. Sticky mode always uses the direct path, whatever filter length is programmed.

Top module: `wk_wake_gen`

## Requirements
- R1: The raw request is the OR of all fabric outputs whose mask bit is 1. With filter length code 0 (bypass) and sticky mode off, `wake_req` equals the raw request of the previous clock cycle.
- R2: An output whose mask bit is 0 has no effect on `wake_req`. With an all-zero mask, `wake_req` never asserts.
- R3: A synchronous active-high `rst` clears `wake_req` to 0 at the next clock edge. Filter length code 0 means bypass, and it is the configuration expected after reset.
- R4: With `sticky_en` = 1, `wake_req` stays 1 once it has been captured, for as long as `sw_clear` is 0, even after the raw request falls.
- R5: With `sticky_en` = 1, a `sw_clear` pulse while the raw request is 0 drops `wake_req` to 0 at the next clock edge.
- R6: With `sticky_en` = 1, a raw request that is high in a cycle sets `wake_req` at the next edge. This set wins over a coincident `sw_clear`.
- R7: With `flt_len` = N (1..3), the filter changes its level only on a cycle where `flt_tick` = 1. It takes a new level only after N consecutive tick samples of the synchronized request have shown that level. Shorter pulses are rejected.
- R8: With sticky mode off and `flt_len` nonzero, `wake_req` follows the filter one cycle later. With a tick every cycle, a raw rise held for N cycles reaches `wake_req` 3+N edges after it is first sampled.
- R9: With `sticky_en` = 1, a nonzero `flt_len` is ignored: a single-cycle raw pulse is still captured at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| fab_out | input | 8 | Fabric output levels |
| out_mask | input | 8 | Per-output enable mask, bit i gates fab_out[i] |
| flt_len | input | 2 | Filter length code: 0 bypass, 1..3 ticks |
| flt_tick | input | 1 | Filter-clock sample strobe |
| sticky_en | input | 1 | Sticky (hold until cleared) mode |
| sw_clear | input | 1 | One-cycle software clear of the sticky request |
| wake_req | output | 1 | Registered wake-up/interrupt request |

## Verification
The bench aims pulses one tick shorter than the filter length and exactly as long as it. A filter that miscounts either lets glitches through or swallows valid requests. A sticky-mode clear is driven in the same cycle as a high raw request, where a design with the wrong priority would drop a live request. Outputs whose mask bit is 0 and a fully zero mask are toggled, which exposes a combiner that ignores the mask. Random phases change the filter length, the tick rate and the mode against a cycle model, which catches latency that is off by one in the synchronizer or the output register.

// File: rtl/wk_pkg.sv
package wk_pkg;
  localparam int LEN_W = 2;

  typedef enum logic [LEN_W-1:0] {
    FLT_BYPASS = 2'd0,
    FLT_ONE    = 2'd1,
    FLT_TWO    = 2'd2,
    FLT_THREE  = 2'd3
  } flt_len_e;

  function automatic logic len_is_bypass(input logic [LEN_W-1:0] len);
    return len == FLT_BYPASS;
  endfunction
endpackage

// File: rtl/wk_combine.sv
module wk_combine #(
  parameter int NOUT = 8
) (
  input  logic [NOUT-1:0] fab_out,
  input  logic [NOUT-1:0] out_mask,
  output logic            raw_req
);
  logic [NOUT-1:0] gated;

  for (genvar i = 0; i < NOUT; i++) begin : g_gate
    assign gated[i] = fab_out[i] & out_mask[i];
  end

  assign raw_req = |gated;
endmodule

// File: rtl/wk_sync.sv
module wk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= 1'b0;
        else     chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= 1'b0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/wk_glitch_filter.sv
module wk_glitch_filter #(
  parameter int LEN_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [LEN_W-1:0] len,
  input  logic             d,
  output logic             q
);
  localparam int CW = LEN_W + 1;

  logic [LEN_W-1:0] run_cnt;
  logic             lvl_q;
  logic [CW-1:0]    run_next;

  assign run_next = {1'b0, run_cnt} + CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      lvl_q   <= 1'b0;
    end else if (tick) begin
      if (d == lvl_q) begin
        run_cnt <= '0;
      end else if (run_next >= {1'b0, len}) begin
        lvl_q   <= d;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_next[LEN_W-1:0];
      end
    end
  end

  assign q = lvl_q;

  AST_FILT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(lvl_q)); // R7
endmodule

// File: rtl/wk_req_cond.sv
module wk_req_cond (
  input  logic clk,
  input  logic rst,
  input  logic raw_req,
  input  logic filt_lvl,
  input  logic bypass,
  input  logic sticky_en,
  input  logic sw_clear,
  output logic req_q
);
  logic req_d;

  always_comb begin
    if (sticky_en)   req_d = raw_req | (req_q & ~sw_clear);
    else if (bypass) req_d = raw_req;
    else             req_d = filt_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= req_d;
  end

  AST_BYPASS_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (!sticky_en && bypass) |=> (req_q == $past(raw_req))); // R1
  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (rst)
    (sticky_en && req_q && !sw_clear) |=> req_q); // R4
  AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (sticky_en && sw_clear && !raw_req) |=> !req_q); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (sticky_en && raw_req) |=> req_q); // R6
  AST_FILT_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (!sticky_en && !bypass) |=> (req_q == $past(filt_lvl))); // R8
endmodule

// File: rtl/wk_wake_gen.sv
module wk_wake_gen #(
  parameter int NOUT        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NOUT-1:0]          fab_out,
  input  logic [NOUT-1:0]          out_mask,
  input  logic [wk_pkg::LEN_W-1:0] flt_len,
  input  logic                     flt_tick,
  input  logic                     sticky_en,
  input  logic                     sw_clear,
  output logic                     wake_req
);
  import wk_pkg::*;

  logic raw_req;
  logic sync_req;
  logic filt_lvl;
  logic bypass;

  assign bypass = len_is_bypass(flt_len);

  wk_combine #(.NOUT(NOUT)) u_combine (
    .fab_out  (fab_out),
    .out_mask (out_mask),
    .raw_req  (raw_req)
  );

  wk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_req),
    .q   (sync_req)
  );

  wk_glitch_filter #(.LEN_W(LEN_W)) u_filter (
    .clk  (clk),
    .rst  (rst),
    .tick (flt_tick),
    .len  (flt_len),
    .d    (sync_req),
    .q    (filt_lvl)
  );

  wk_req_cond u_cond (
    .clk       (clk),
    .rst       (rst),
    .raw_req   (raw_req),
    .filt_lvl  (filt_lvl),
    .bypass    (bypass),
    .sticky_en (sticky_en),
    .sw_clear  (sw_clear),
    .req_q     (wake_req)
  );

  AST_MASK_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_mask == '0 && !sticky_en && bypass) |=> !wake_req); // R2
endmodule

// File: tb/wk_wake_gen_bench.sv
module wk_wake_gen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] fab_out = '0;
  logic [7:0] out_mask = '0;
  logic [1:0] flt_len = '0;
  logic       flt_tick = 1'b0;
  logic       sticky_en = 1'b0;
  logic       sw_clear = 1'b0;
  logic       wake_req;

  int total = 0;
  int bad = 0;
  logic saw_high;

  always #5 clk = ~clk;

  wk_wake_gen u_wk_wake_gen (
    .clk       (clk),
    .rst       (rst),
    .fab_out   (fab_out),
    .out_mask  (out_mask),
    .flt_len   (flt_len),
    .flt_tick  (flt_tick),
    .sticky_en (sticky_en),
    .sw_clear  (sw_clear),
    .wake_req  (wake_req)
  );

  // cycle model built from the requirements
  logic m_s1, m_s2, m_lvl, m_req;
  logic [1:0] m_cnt;

  function automatic logic f_raw(input logic [7:0] f, input logic [7:0] m);
    return |(f & m);
  endfunction

  always @(posedge clk) begin
    logic raw, nlvl, nreq;
    logic [1:0] ncnt;
    raw  = f_raw(fab_out, out_mask);
    nlvl = m_lvl;
    ncnt = m_cnt;
    if (flt_tick) begin
      if (m_s2 == m_lvl) ncnt = 2'd0;
      else if (({1'b0, m_cnt} + 3'd1) >= {1'b0, flt_len}) begin
        nlvl = m_s2; ncnt = 2'd0;
      end else ncnt = m_cnt + 2'd1;
    end
    if (sticky_en)          nreq = raw | (m_req & ~sw_clear);
    else if (flt_len == 0)  nreq = raw;
    else                    nreq = m_lvl;
    if (rst) begin
      m_s1 <= 0; m_s2 <= 0; m_lvl <= 0; m_cnt <= 0; m_req <= 0;
    end else begin
      m_s1 <= raw; m_s2 <= m_s1; m_lvl <= nlvl; m_cnt <= ncnt; m_req <= nreq;
    end
  end

  task automatic chk(input logic exp, input string req);
    total++;
    if (wake_req !== exp) begin
      bad++;
      $display("FAIL %s: wake_req=%0b expected=%0b at %0t", req, wake_req, exp, $time);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) nxt();
    rst = 1'b0;
    nxt();
    chk(1'b0, "R3 reset value");

    // R1 bypass: one-cycle latency
    out_mask = 8'h04; fab_out = 8'h04;
    nxt(); chk(1'b1, "R1 bypass capture");
    fab_out = 8'h08;
    nxt(); chk(1'b0, "R2 unmasked output ignored");
    fab_out = 8'h00;
    nxt();

    // R2 zero mask
    out_mask = 8'h00; fab_out = 8'hFF;
    for (int i = 0; i < 10; i++) begin
      nxt(); chk(1'b0, "R2 zero mask");
    end
    fab_out = 8'h00; out_mask = 8'hFF;
    nxt();

    // R4 / R5 / R6 sticky mode
    sticky_en = 1'b1; fab_out = 8'h01;
    nxt(); chk(1'b1, "R6 sticky set");
    fab_out = 8'h00;
    for (int i = 0; i < 5; i++) begin
      nxt(); chk(1'b1, "R4 sticky hold");
    end
    fab_out = 8'h01; sw_clear = 1'b1;
    nxt(); chk(1'b1, "R6 set beats clear");
    fab_out = 8'h00;
    nxt(); chk(1'b0, "R5 clear drops");
    sw_clear = 1'b0;
    nxt(); chk(1'b0, "R5 stays cleared");

    // R9 sticky ignores filter length
    flt_len = 2'd3; flt_tick = 1'b1; fab_out = 8'h80;
    nxt(); chk(1'b1, "R9 filter ignored in sticky mode");
    fab_out = 8'h00; sw_clear = 1'b1;
    nxt(); chk(1'b0, "R5 clear with filter set");
    sw_clear = 1'b0; sticky_en = 1'b0;
    repeat (8) nxt();

    // R7 short pulse rejected (2 cycles, length 3)
    fab_out = 8'h10;
    nxt(); nxt();
    fab_out = 8'h00;
    saw_high = 1'b0;
    for (int i = 0; i < 12; i++) begin
      nxt(); if (wake_req) saw_high = 1'b1;
    end
    total++;
    if (saw_high) begin
      bad++; $display("FAIL R7 short pulse passed: actual=1 expected=0");
    end

    // R8 pulse of exactly 3 reaches output at edge 6
    fab_out = 8'h10;
    nxt(); chk(1'b0, "R8 latency e1");
    nxt(); chk(1'b0, "R8 latency e2");
    nxt(); chk(1'b0, "R8 latency e3");
    fab_out = 8'h00;
    nxt(); chk(1'b0, "R8 latency e4");
    nxt(); chk(1'b0, "R8 latency e5");
    nxt(); chk(1'b1, "R8 filtered request after 3+N");
    repeat (10) nxt();
    chk(1'b0, "R7 filtered fall");

    // R7 no tick, no change
    flt_tick = 1'b0; fab_out = 8'h10;
    for (int i = 0; i < 10; i++) begin
      nxt(); chk(1'b0, "R7 frozen without tick");
    end
    fab_out = 8'h00;

    // random phase against the model
    rst = 1'b1; nxt(); rst = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      nxt();
      chk(m_req, "R1 R7 R8 random vs model");
      if ($urandom_range(0, 99) < 25) fab_out = 8'($urandom);
      if ($urandom_range(0, 199) == 0) out_mask = 8'($urandom);
      if ($urandom_range(0, 299) == 0) flt_len = 2'($urandom);
      if ($urandom_range(0, 399) == 0) sticky_en = ~sticky_en;
      flt_tick = ($urandom_range(0, 3) != 0);
      sw_clear = ($urandom_range(0, 19) == 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule